// File: doc/BRIEF.md
# Four-lane 7:1 pixel serializer

The block turns one 28-bit pixel word per pixel period into four serial data lanes and one framing clock lane. Everything runs from a single bit-rate clock. One pixel period is seven of its cycles. A pixel strobe at pixel rate is sampled in the same clock domain. Its rising or falling transition, chosen by an edge-select input, captures the input word into a holding register.

A free-running modulo-7 slot counter reloads the four lane shift registers from the holding register at every slot-6 boundary. The lanes therefore carry a continuous stream with no idle bit between pixels. Each lane sends its seven bits in a fixed scrambled order. The clock lane repeats a four-high, three-low pattern whose rising edge marks slot 0.

An active-low shutdown input asynchronously clears every register and forces all lanes low. A valid flag tells the consumer when the stream first carries captured data.

Top module: `pix7_serializer`

## Requirements
- R1: Lane 0 sends, in slots 0 to 6, input bits 1, 0, 7, 6, 4, 3, 2. Lane 1 sends bits 9, 8, 18, 15, 14, 13, 12. Bit k of `lane_o` is lane k.
- R2: Lane 2 sends, in slots 0 to 6, input bits 20, 19, 26, 25, 24, 22, 21. Lane 3 sends bits 5, 27, 23, 17, 16, 11, 10.
- R3: With shutdown released, `clk_lane_o` is 1 in slots 0 to 3 and 0 in slots 4 to 6, so its only rising edge coincides with slot 0.
- R4: With `rise_sel` = 1, the word is captured at each clock edge where the sampled `pix_strobe` goes from 0 to 1.
- R5: With `rise_sel` = 0, the word is captured where `pix_strobe` goes from 1 to 0, and 0-to-1 transitions capture nothing.
- R6: While `shdn_n` is 0, all outputs are 0 and all state is cleared. After release the slot counter starts at slot 0, and each later clock edge advances it by one.
- R7: `valid_o` stays 0 after shutdown release until the first reload that follows a capture. It rises together with that word's slot 0 and then stays 1 until the next shutdown.
- R8: A captured word is reloaded at the first later clock edge where the slot counter is 6. A capture on the same edge as a reload waits for the next one. Consecutive words follow each other with no gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock, seven cycles per pixel |
| shdn_n | input | 1 | Active-low shutdown and asynchronous clear |
| rise_sel | input | 1 | 1 captures on strobe rise, 0 on strobe fall |
| pix_strobe | input | 1 | Pixel-rate strobe sampled in the clk domain |
| pix_word | input | 28 | Parallel pixel word |
| lane_o | output | 4 | Serial data lanes, bit k is lane k |
| clk_lane_o | output | 1 | Framing clock lane |
| valid_o | output | 1 | Stream carries captured data |

## Verification
The bench builds the block with its default parameters: four lanes, seven slots, four high clock slots, and the scrambled order. Only this variant exposes the fixed bit order and the asymmetric clock pattern.

Single-bit words walked over all 28 positions pin each input bit to its lane and slot. Random words that change every cycle catch capture on the wrong edge or in the wrong cycle. Moving the strobe phase relative to the slot counter places captures on, before and after the reload edge. A mid-stream shutdown exercises the clear and the return of the valid flag.

// File: rtl/pix7_ser_pkg.sv
package pix7_ser_pkg;

   // Source bit of the scrambled four-lane, seven-slot order.
   function automatic int scramble_src(input int lane, input int slot);
      int r;
      case (lane * 7 + slot)
         0:  r = 1;   1:  r = 0;   2:  r = 7;   3:  r = 6;
         4:  r = 4;   5:  r = 3;   6:  r = 2;
         7:  r = 9;   8:  r = 8;   9:  r = 18;  10: r = 15;
         11: r = 14;  12: r = 13;  13: r = 12;
         14: r = 20;  15: r = 19;  16: r = 26;  17: r = 25;
         18: r = 24;  19: r = 22;  20: r = 21;
         21: r = 5;   22: r = 27;  23: r = 23;  24: r = 17;
         25: r = 16;  26: r = 11;  27: r = 10;
         default: r = 0;
      endcase
      return r;
   endfunction

   // Source bit for either order variant.
   function automatic int lane_src(input bit scr, input int lane, input int slot,
                                   input int slots);
      return scr ? scramble_src(lane, slot) : lane * slots + slot;
   endfunction

endpackage

// File: rtl/pix7_capture.sv
module pix7_capture #(
   parameter int WORD_W = 28
) (
   input  logic              clk,
   input  logic              shdn_n,
   input  logic              rise_sel,
   input  logic              strobe_i,
   input  logic [WORD_W-1:0] word_i,
   output logic [WORD_W-1:0] hold_o,
   output logic              have_o
);

   logic strobe_q;
   logic take;

   assign take = rise_sel ? (strobe_i & ~strobe_q) : (~strobe_i & strobe_q);

   always_ff @(posedge clk or negedge shdn_n) begin
      if (!shdn_n) begin
         strobe_q <= 1'b0;
         hold_o   <= '0;
         have_o   <= 1'b0;
      end else begin
         strobe_q <= strobe_i;
         if (take) begin
            hold_o <= word_i;
            have_o <= 1'b1;
         end
      end
   end

   // R4 / R5: a selected strobe transition lands the word in the holding register
   assert_capture_word_R4: assert property (@(posedge clk) disable iff (!shdn_n)
      take |=> (hold_o == $past(word_i)));

   // R5: an unselected transition leaves the held word alone
   assert_other_edge_ignored_R5: assert property (@(posedge clk) disable iff (!shdn_n)
      (!take && have_o) |=> $stable(hold_o));

endmodule

// File: rtl/pix7_slot_timer.sv
module pix7_slot_timer #(
   parameter int SLOTS    = 7,
   parameter int CLK_HIGH = 4,
   localparam int SW      = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
   input  logic          clk,
   input  logic          shdn_n,
   output logic [SW-1:0] slot_o,
   output logic          load_o,
   output logic          clk_pat_o
);

   localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);
   localparam logic [SW-1:0] HIGH = SW'(CLK_HIGH);

   always_ff @(posedge clk or negedge shdn_n) begin
      if (!shdn_n)             slot_o <= '0;
      else if (slot_o == LAST) slot_o <= '0;
      else                     slot_o <= slot_o + 1'b1;
   end

   assign load_o    = (slot_o == LAST);
   assign clk_pat_o = (slot_o < HIGH);

   // R8: the counter stays within the slot range and wraps after the last slot
   assert_slot_range_R8: assert property (@(posedge clk) disable iff (!shdn_n)
      slot_o <= LAST);
   assert_slot_wrap_R8: assert property (@(posedge clk) disable iff (!shdn_n)
      (slot_o == LAST) |=> (slot_o == '0));

endmodule

// File: rtl/pix7_lane_shift.sv
module pix7_lane_shift #(
   parameter int SLOTS    = 7,
   parameter int WORD_W   = 28,
   parameter int LANE     = 0,
   parameter bit SCRAMBLE = 1'b1
) (
   input  logic              clk,
   input  logic              shdn_n,
   input  logic              load_i,
   input  logic [WORD_W-1:0] word_i,
   output logic              ser_o
);

   logic [SLOTS-1:0] frame;
   logic [SLOTS-1:0] sh_q;

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      localparam int SRC = pix7_ser_pkg::lane_src(SCRAMBLE, LANE, s, SLOTS);
      if (SRC >= WORD_W) begin : g_bad_src
         $error("lane source bit out of range");
      end
      assign frame[s] = word_i[SRC];
   end

   always_ff @(posedge clk or negedge shdn_n) begin
      if (!shdn_n)     sh_q <= '0;
      else if (load_i) sh_q <= frame;
      else             sh_q <= {1'b0, sh_q[SLOTS-1:1]};
   end

   assign ser_o = sh_q[0];

endmodule

// File: rtl/pix7_serializer.sv
module pix7_serializer #(
   parameter int LANES    = 4,
   parameter int SLOTS    = 7,
   parameter int CLK_HIGH = 4,
   parameter bit SCRAMBLE = 1'b1,
   localparam int WORD_W  = LANES * SLOTS,
   localparam int SW      = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
   input  logic              clk,
   input  logic              shdn_n,
   input  logic              rise_sel,
   input  logic              pix_strobe,
   input  logic [WORD_W-1:0] pix_word,
   output logic [LANES-1:0]  lane_o,
   output logic              clk_lane_o,
   output logic              valid_o
);

   if (SLOTS < 2) begin : g_bad_slots
      $error("SLOTS must be at least 2");
   end
   if (CLK_HIGH < 1 || CLK_HIGH >= SLOTS) begin : g_bad_high
      $error("CLK_HIGH must lie between 1 and SLOTS-1");
   end
   if (SCRAMBLE && (LANES != 4 || SLOTS != 7)) begin : g_bad_scr
      $error("scrambled order needs 4 lanes of 7 slots");
   end

   logic [WORD_W-1:0] hold;
   logic              have;
   logic [SW-1:0]     slot;
   logic              load;
   logic              clk_pat;
   logic [LANES-1:0]  ser;
   logic              valid_q;

   pix7_capture #(.WORD_W(WORD_W)) u_cap (
      .clk(clk), .shdn_n(shdn_n), .rise_sel(rise_sel), .strobe_i(pix_strobe),
      .word_i(pix_word), .hold_o(hold), .have_o(have));

   pix7_slot_timer #(.SLOTS(SLOTS), .CLK_HIGH(CLK_HIGH)) u_tmr (
      .clk(clk), .shdn_n(shdn_n), .slot_o(slot), .load_o(load), .clk_pat_o(clk_pat));

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      pix7_lane_shift #(.SLOTS(SLOTS), .WORD_W(WORD_W), .LANE(l), .SCRAMBLE(SCRAMBLE)) u_sh (
         .clk(clk), .shdn_n(shdn_n), .load_i(load), .word_i(hold), .ser_o(ser[l]));
   end

   always_ff @(posedge clk or negedge shdn_n) begin
      if (!shdn_n)          valid_q <= 1'b0;
      else if (load & have) valid_q <= 1'b1;
   end

   assign lane_o     = shdn_n ? ser : '0;
   assign clk_lane_o = shdn_n & clk_pat;
   assign valid_o    = valid_q;

   localparam int SRC00 = pix7_ser_pkg::lane_src(SCRAMBLE, 0, 0, SLOTS);

   // R1 / R8: slot 0 of lane 0 carries the word held at the reload edge
   assert_lane0_slot0_R1: assert property (@(posedge clk) disable iff (!shdn_n)
      (slot == '0) |-> (lane_o[0] == $past(hold[SRC00])));

   // R3: the clock lane rises only at slot 0
   assert_clk_rise_slot0_R3: assert property (@(posedge clk) disable iff (!shdn_n)
      $rose(clk_lane_o) |-> (slot == '0));

   // R7: valid never drops without shutdown and rises only at slot 0
   assert_valid_sticky_R7: assert property (@(posedge clk) disable iff (!shdn_n)
      valid_o |=> valid_o);
   assert_valid_rise_slot0_R7: assert property (@(posedge clk) disable iff (!shdn_n)
      $rose(valid_o) |-> (slot == '0));

endmodule

// File: tb/tb_pix7_serializer.sv
module tb_pix7_serializer;

   logic        clk = 1'b0;
   logic        shdn_n = 1'b0;
   logic        rise_sel = 1'b1;
   logic        pix_strobe = 1'b0;
   logic [27:0] pix_word = '0;
   logic [3:0]  lane_o;
   logic        clk_lane_o;
   logic        valid_o;

   always #4 clk = ~clk;

   pix7_serializer dut (
      .clk(clk), .shdn_n(shdn_n), .rise_sel(rise_sel), .pix_strobe(pix_strobe),
      .pix_word(pix_word), .lane_o(lane_o), .clk_lane_o(clk_lane_o), .valid_o(valid_o));

   int    checks = 0;
   int    failures = 0;
   string phase = "R6 reset";
   bit    done = 1'b0;

   // Lane order from R1 and R2.
   int lane_map [4][7] = '{'{1, 0, 7, 6, 4, 3, 2},
                           '{9, 8, 18, 15, 14, 13, 12},
                           '{20, 19, 26, 25, 24, 22, 21},
                           '{5, 27, 23, 17, 16, 11, 10}};

   // Behavioural reference state.
   int          m_slot = 0;
   bit          m_prev = 0, m_have = 0, m_vld = 0;
   logic [27:0] m_hold = '0;
   bit          m_frame [4][7];
   bit          m_bits [$];

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s [%s] %s got=%0d exp=%0d", req, phase, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      if (!shdn_n) begin
         m_slot = 0; m_prev = 0; m_have = 0; m_vld = 0; m_hold = '0;
         foreach (m_frame[l, s]) m_frame[l][s] = 0;
      end else begin
         if (m_slot == 6) begin
            m_bits.delete();
            for (int l = 0; l < 4; l++)
               for (int s = 0; s < 7; s++) m_bits.push_back(m_hold[lane_map[l][s]]);
            for (int l = 0; l < 4; l++)
               for (int s = 0; s < 7; s++) m_frame[l][s] = m_bits.pop_front();
            if (m_have) m_vld = 1;
         end
         if ((rise_sel && pix_strobe && !m_prev) || (!rise_sel && !pix_strobe && m_prev)) begin
            m_hold = pix_word;
            m_have = 1;
         end
         m_prev = pix_strobe;
         m_slot = (m_slot + 1) % 7;
      end
      #2;
      for (int l = 0; l < 4; l++) begin
         bit e;
         e = shdn_n ? m_frame[l][m_slot] : 1'b0;
         check(lane_o[l] === e, (l < 2) ? "R1" : "R2", $sformatf("lane%0d slot%0d", l, m_slot),
               int'(lane_o[l]), int'(e));
      end
      check(clk_lane_o === (shdn_n && m_slot < 4), "R3", $sformatf("clk lane slot%0d", m_slot),
            int'(clk_lane_o), int'(shdn_n && m_slot < 4));
      check(valid_o === (shdn_n && m_vld), "R7", "valid", int'(valid_o), int'(shdn_n && m_vld));
   end

   int cnt = 0;

   task automatic run(input int n, input int offs, input bit rnd, input logic [27:0] w);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         cnt++;
         pix_strobe = ((cnt + offs) % 7) < 4;
         pix_word   = rnd ? 28'($urandom) : w;
      end
   endtask

   initial begin
      run(5, 0, 1'b1, '0);
      @(negedge clk);
      check(lane_o === 4'b0 && clk_lane_o === 1'b0 && valid_o === 1'b0, "R6",
            "outputs in shutdown", int'({lane_o, clk_lane_o, valid_o}), 0);
      shdn_n = 1'b1;
      phase = "R7 after release";
      run(3, 0, 1'b0, 28'h0);
      phase = "R4 R8 walking bit";
      for (int k = 0; k < 28; k++) run(14, 0, 1'b0, 28'(1) << k);
      for (int o = 0; o < 7; o++) begin
         phase = $sformatf("R4 R8 random offs%0d", o);
         run(40, o, 1'b1, '0);
      end
      @(negedge clk); rise_sel = 1'b0;
      for (int o = 0; o < 7; o++) begin
         phase = $sformatf("R5 falling offs%0d", o);
         run(40, o, 1'b1, '0);
      end
      phase = "R6 mid-stream shutdown";
      @(negedge clk); shdn_n = 1'b0;
      run(6, 2, 1'b1, '0);
      check(lane_o === 4'b0 && clk_lane_o === 1'b0 && valid_o === 1'b0, "R6",
            "outputs in shutdown", int'({lane_o, clk_lane_o, valid_o}), 0);
      shdn_n = 1'b1; rise_sel = 1'b1;
      phase = "R7 R8 restart";
      run(120, 5, 1'b1, '0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule